// File: doc/BRIEF.md
# Dual-Mode Program Counter and Branch Unit

This block holds the program counter of a core that can execute from two places. In local-register mode instructions sit in word-addressed registers, and one instruction is one address step. In shared-memory mode instructions sit in byte-addressed memory, and each one is four bytes wide. Every cycle in which an instruction retires, the block forms the next PC from the current mode, the instruction class, its immediate field and the evaluated branch condition. Decode, condition evaluation and fetch stay outside the block.

Branch immediates have one binary encoding for both modes. The block rescales them by the mode, so the same branch word is correct wherever it runs. Short relative branches count in instructions and are scaled up by four in shared-memory mode. Long relative branches count in bytes and are scaled down by four in local-register mode.

A hardware repeat controller runs a block of instructions a given number of times. In shared-memory mode each return to the top of the block acts as a forced jump and raises the refetch flag. In local-register mode the return costs nothing.

Top module: `dual_pc_unit`

## Requirements
- R1: During synchronous reset and on the first cycle after it, `pc` equals the RESET_PC parameter (default 0), and `redirect` and `loop_busy` are 0.
- R2: When `step` is 0, `pc` keeps its value and `redirect` is 0. With `step` high and `op`=2'b00 (sequential) outside a loop end, `pc` advances by 1 when `mode`=0 and by 4 when `mode`=1.
- R3: Every new `pc` is reduced modulo 512 when `mode`=0 (local-register mode) and modulo 2^20 when `mode`=1 (shared-memory mode).
- R4: For `op`=2'b01 (short branch), `imm[8:0]` is a signed instruction count from -256 to +255. When `cond`=1, the new `pc` is `pc` plus that value, multiplied by 4 when `mode`=1. When `cond`=0, the branch falls through as in R2.
- R5: For `op`=2'b10 (long branch, unconditional), `imm[19:0]` is a signed byte offset. When `mode`=1 it is added to `pc` as is. When `mode`=0 it is first shifted right arithmetically by two.
- R6: For `op`=2'b11 (repeat) with `rep_count`≠0, the block start is the next sequential address and the block end is the start plus `imm[8:0]` instruction steps. `loop_busy` goes to 1. A sequential instruction at the block end returns `pc` to the start until the block has run `rep_count` times, and then falls through and clears `loop_busy`.
- R7: Repeat with `rep_count`=0 skips the block: `pc` becomes the block end plus one instruction step, `loop_busy` is 0 and `redirect` is 1.
- R8: `redirect` is 1 in the cycle after a taken short branch, any long branch or a repeat skip. It is 0 after a sequential step, an untaken branch or a repeat that arms a loop.
- R9: A return to the block start raises `redirect` when `mode`=1 and does not raise it when `mode`=0.
- R10: A taken branch at the block end takes priority over the loop return and leaves the remaining iteration count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | An instruction retires this cycle |
| mode | input | 1 | 0 local-register mode, 1 shared-memory mode |
| op | input | 2 | 00 sequential, 01 short branch, 10 long branch, 11 repeat |
| cond | input | 1 | Short-branch condition result |
| imm | input | 20 | Immediate field of the instruction |
| rep_count | input | 16 | Iteration count for repeat |
| pc | output | 20 | Registered program counter |
| redirect | output | 1 | Last PC change needs a refetch |
| loop_busy | output | 1 | Repeat loop is armed |

## Verification
Wrong loop state shows at the port on the first retire at the block end. A bad start or end address, or a remaining count that is off by one, moves `pc` to the wrong value one cycle after that instruction. A scaling error in either mode shows one cycle after the branch as a `pc` that is off by a factor of four. A mask error shows when `pc` passes 511 or 2^20-4. The bench's reference model checks `pc`, `redirect` and `loop_busy` on every cycle, so a fault is reported in the cycle after the step that exposes it.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    OP_SEQ = 2'b00,
    OP_SBR = 2'b01,
    OP_LBR = 2'b10,
    OP_REP = 2'b11
  } op_e;
endpackage

// File: rtl/dpc_target.sv
module dpc_target #(
  parameter int PC_W  = 20,
  parameter int LOC_W = 9,
  parameter int OFF_W = 9
) (
  input  logic            mode,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] imm,
  output logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] sbr_pc,
  output logic [PC_W-1:0] lbr_pc,
  output logic [PC_W-1:0] last_pc,
  output logic [PC_W-1:0] skip_pc
);
  localparam int HI_W = PC_W - LOC_W;
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] mask, inc, s_ext, s_off, l_off, len_ext, len_off;

  always_comb begin
    mask    = mode ? {PC_W{1'b1}} : {{HI_W{1'b0}}, {LOC_W{1'b1}}};
    inc     = mode ? PC_W'(4) : PC_W'(1);
    s_ext   = {{EXT_W{imm[OFF_W-1]}}, imm[OFF_W-1:0]};
    s_off   = mode ? (s_ext << 2) : s_ext;
    l_off   = mode ? imm : {{2{imm[PC_W-1]}}, imm[PC_W-1:2]};
    len_ext = {{EXT_W{1'b0}}, imm[OFF_W-1:0]};
    len_off = mode ? (len_ext << 2) : len_ext;
    seq_pc  = (pc + inc) & mask;
    sbr_pc  = (pc + s_off) & mask;
    lbr_pc  = (pc + l_off) & mask;
    last_pc = (seq_pc + len_off) & mask;
    skip_pc = (last_pc + inc) & mask;
  end
endmodule

// File: rtl/dpc_loop.sv
module dpc_loop #(
  parameter int PC_W  = 20,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             is_seq,
  input  logic             is_rep,
  input  logic [CNT_W-1:0] cnt,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  arm_start,
  input  logic [PC_W-1:0]  arm_last,
  output logic             busy,
  output logic             wrap,
  output logic [PC_W-1:0]  start_pc
);
  logic [PC_W-1:0]  last_q;
  logic [CNT_W-1:0] rem_q;
  logic             at_end;

  assign at_end = busy && step && is_seq && (pc == last_q);
  assign wrap   = at_end && (rem_q > CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      start_pc <= '0;
      last_q   <= '0;
      rem_q    <= '0;
    end else if (step && is_rep) begin
      busy     <= (cnt != '0);
      start_pc <= arm_start;
      last_q   <= arm_last;
      rem_q    <= cnt;
    end else if (at_end) begin
      if (rem_q > CNT_W'(1)) rem_q <= rem_q - CNT_W'(1);
      else                   busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_pc_unit.sv
module dual_pc_unit #(
  parameter int PC_W     = 20,
  parameter int LOC_W    = 9,
  parameter int OFF_W    = 9,
  parameter int CNT_W    = 16,
  parameter int RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             mode,
  input  logic [1:0]       op,
  input  logic             cond,
  input  logic [PC_W-1:0]  imm,
  input  logic [CNT_W-1:0] rep_count,
  output logic [PC_W-1:0]  pc,
  output logic             redirect,
  output logic             loop_busy
);
  import dpc_pkg::*;

  op_e             op_t;
  logic [PC_W-1:0] seq_pc, sbr_pc, lbr_pc, last_pc, skip_pc, start_pc;
  logic [PC_W-1:0] pc_nxt;
  logic            red_nxt, wrap;

  assign op_t = op_e'(op);

  dpc_target #(.PC_W(PC_W), .LOC_W(LOC_W), .OFF_W(OFF_W)) u_tgt (
    .mode(mode), .pc(pc), .imm(imm),
    .seq_pc(seq_pc), .sbr_pc(sbr_pc), .lbr_pc(lbr_pc),
    .last_pc(last_pc), .skip_pc(skip_pc)
  );

  dpc_loop #(.PC_W(PC_W), .CNT_W(CNT_W)) u_loop (
    .clk(clk), .rst(rst), .step(step),
    .is_seq(op_t == OP_SEQ), .is_rep(op_t == OP_REP),
    .cnt(rep_count), .pc(pc), .arm_start(seq_pc), .arm_last(last_pc),
    .busy(loop_busy), .wrap(wrap), .start_pc(start_pc)
  );

  always_comb begin
    pc_nxt  = pc;
    red_nxt = 1'b0;
    if (step) begin
      case (op_t)
        OP_SEQ: begin
          pc_nxt  = wrap ? start_pc : seq_pc;
          red_nxt = wrap && mode;
        end
        OP_SBR: begin
          pc_nxt  = cond ? sbr_pc : seq_pc;
          red_nxt = cond;
        end
        OP_LBR: begin
          pc_nxt  = lbr_pc;
          red_nxt = 1'b1;
        end
        default: begin
          pc_nxt  = (rep_count == '0) ? skip_pc : seq_pc;
          red_nxt = (rep_count == '0);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= PC_W'(RESET_PC);
      redirect <= 1'b0;
    end else begin
      pc       <= pc_nxt;
      redirect <= red_nxt;
    end
  end
endmodule

// File: rtl/dual_pc_unit_chk.sv
module dual_pc_unit_chk #(
  parameter int PC_W  = 20,
  parameter int LOC_W = 9,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             step,
  input logic             mode,
  input logic [1:0]       op,
  input logic             cond,
  input logic [CNT_W-1:0] rep_count,
  input logic [PC_W-1:0]  pc,
  input logic             redirect,
  input logic             loop_busy
);
  function automatic logic [PC_W-1:0] adv(input logic [PC_W-1:0] p, input logic m);
    logic [PC_W-1:0] msk;
    msk = m ? {PC_W{1'b1}} : PC_W'((1 << LOC_W) - 1);
    return (p + (m ? PC_W'(4) : PC_W'(1))) & msk;
  endfunction

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pc) && !redirect); // R2
  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    step && op == 2'b00 && !loop_busy |=> pc == adv($past(pc), $past(mode))); // R2
  AST_LOCAL_RANGE: assert property (@(posedge clk) disable iff (rst)
    step && !mode |=> pc[PC_W-1:LOC_W] == '0); // R3
  AST_UNTAKEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    step && op == 2'b01 && !cond |=> !redirect); // R4
  AST_LONG_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    step && op == 2'b10 |=> redirect); // R8
  AST_REP_ARM: assert property (@(posedge clk) disable iff (rst)
    step && op == 2'b11 && rep_count != '0 |=> loop_busy && !redirect); // R6
  AST_REP_SKIP: assert property (@(posedge clk) disable iff (rst)
    step && op == 2'b11 && rep_count == '0 |=> !loop_busy && redirect); // R7
  AST_LOCAL_WRAP_FREE: assert property (@(posedge clk) disable iff (rst)
    step && !mode && op == 2'b00 |=> !redirect); // R9
endmodule

bind dual_pc_unit dual_pc_unit_chk #(.PC_W(PC_W), .LOC_W(LOC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .step(step), .mode(mode), .op(op), .cond(cond),
  .rep_count(rep_count), .pc(pc), .redirect(redirect), .loop_busy(loop_busy)
);

// File: tb/sim_dual_pc_unit.sv
module sim_dual_pc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic        mode = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        cond = 1'b0;
  logic [19:0] imm = '0;
  logic [15:0] rep_count = '0;
  logic [19:0] pc;
  logic        redirect, loop_busy;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_pc, m_start, m_last, m_rem;
  bit m_red, m_busy;

  always #5 clk = ~clk;

  dual_pc_unit u0 (
    .clk(clk), .rst(rst), .step(step), .mode(mode), .op(op), .cond(cond),
    .imm(imm), .rep_count(rep_count), .pc(pc), .redirect(redirect),
    .loop_busy(loop_busy)
  );

  task automatic check(input string tag);
    total += 3;
    if (int'(pc) != m_pc) begin
      bad++;
      $display("FAIL %s pc actual=%h expected=%h", tag, pc, m_pc);
    end
    if (redirect != m_red) begin
      bad++;
      $display("FAIL %s redirect actual=%0d expected=%0d", tag, redirect, m_red);
    end
    if (loop_busy != m_busy) begin
      bad++;
      $display("FAIL %s loop_busy actual=%0d expected=%0d", tag, loop_busy, m_busy);
    end
  endtask

  function automatic int sx(input int v, input int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  task automatic model_step();
    int msk, inc, st, ls, off;
    msk = mode ? 'hFFFFF : 'h1FF;
    inc = mode ? 4 : 1;
    m_red = 0;
    if (!step) return;
    case (op)
      2'b00: begin
        if (m_busy && m_pc == m_last) begin
          if (m_rem > 1) begin
            m_pc = m_start; m_rem--; m_red = mode;
          end else begin
            m_pc = (m_pc + inc) & msk; m_busy = 0;
          end
        end else m_pc = (m_pc + inc) & msk;
      end
      2'b01: begin
        if (cond) begin
          m_pc = (m_pc + sx(int'(imm[8:0]), 9) * inc) & msk; m_red = 1;
        end else m_pc = (m_pc + inc) & msk;
      end
      2'b10: begin
        off = sx(int'(imm), 20);
        if (!mode) off = off >>> 2;
        m_pc = (m_pc + off) & msk; m_red = 1;
      end
      default: begin
        st = (m_pc + inc) & msk;
        ls = (st + int'(imm[8:0]) * inc) & msk;
        if (rep_count == 0) begin
          m_pc = (ls + inc) & msk; m_red = 1; m_busy = 0;
        end else begin
          m_pc = st; m_busy = 1; m_start = st; m_last = ls; m_rem = int'(rep_count);
        end
      end
    endcase
  endtask

  task automatic cyc(input logic s, input logic [1:0] o, input logic c,
                     input logic [19:0] im, input logic [15:0] cn, input string tag);
    step = s; op = o; cond = c; imm = im; rep_count = cn;
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_pc = 0; m_red = 0; m_busy = 0; m_start = 0; m_last = 0; m_rem = 0;
    @(negedge clk); @(negedge clk);
    check("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset");
    // local mode
    cyc(0, 2'b00, 0, 0, 0, "R2 idle");
    for (int i = 0; i < 3; i++) cyc(1, 2'b00, 0, 0, 0, "R2 local seq");
    cyc(1, 2'b01, 1, 20'h001FE, 0, "R4 local short back");
    cyc(1, 2'b01, 0, 20'h00055, 0, "R4 untaken");
    cyc(1, 2'b01, 1, 20'h000FF, 0, "R4 local short +255");
    cyc(1, 2'b10, 0, 20'hFFFF8, 0, "R5 local long -8 bytes");
    cyc(1, 2'b10, 0, 20'h00013, 0, "R5 local long +19 bytes");
    cyc(1, 2'b01, 1, 20'h00100, 0, "R3 local wrap via -256");
    for (int i = 0; i < 3; i++) cyc(1, 2'b01, 1, 20'h000FF, 0, "R3 local wrap forward");
    // local repeat: 2 instructions, 3 passes
    cyc(1, 2'b11, 0, 20'h00001, 16'd3, "R6 local arm");
    for (int i = 0; i < 7; i++) cyc(1, 2'b00, 0, 0, 0, "R9 local loop");
    cyc(1, 2'b11, 0, 20'h00002, 16'd0, "R7 local skip");
    cyc(1, 2'b11, 0, 20'h00000, 16'd1, "R6 single pass arm");
    cyc(1, 2'b00, 0, 0, 0, "R6 single pass");
    cyc(1, 2'b00, 0, 0, 0, "R6 after single");
    // branch at block end
    cyc(1, 2'b11, 0, 20'h00001, 16'd2, "R10 arm");
    cyc(1, 2'b00, 0, 0, 0, "R10 body");
    cyc(1, 2'b01, 1, 20'h1FFFF, 0, "R10 branch at end");
    cyc(1, 2'b00, 0, 0, 0, "R10 body again");
    cyc(1, 2'b00, 0, 0, 0, "R10 end wraps");
    cyc(1, 2'b00, 0, 0, 0, "R10 body last");
    cyc(1, 2'b00, 0, 0, 0, "R10 exit");
    // shared mode
    mode = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1, 2'b00, 0, 0, 0, "R2 shared seq");
    cyc(0, 2'b10, 0, 20'h00400, 0, "R2 shared idle");
    cyc(1, 2'b10, 0, 20'h00400, 0, "R5 shared long");
    cyc(1, 2'b01, 1, 20'h001FF, 0, "R4 shared short -1");
    cyc(1, 2'b01, 0, 20'h001FF, 0, "R4 shared untaken");
    cyc(1, 2'b10, 0, 20'(-(m_pc + 4)), 0, "R3 shared to top");
    cyc(1, 2'b00, 0, 0, 0, "R3 shared wrap");
    cyc(1, 2'b11, 0, 20'h00002, 16'd2, "R6 shared arm");
    for (int i = 0; i < 7; i++) cyc(1, 2'b00, 0, 0, 0, "R9 shared loop");
    cyc(1, 2'b11, 0, 20'h00003, 16'd0, "R7 shared skip");
    cyc(1, 2'b00, 0, 0, 0, "R2 shared tail");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule